// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is an up counter in which every register changes only on the rising clock edge. It is built from 4-bit digit stages, and no input acts between edges. Each edge does exactly one of four things, in fixed priority. A low `clear_n` zeroes the word. Otherwise a low `load_n` copies `d` into the counter. Otherwise, when both `cep` and `cet` are high, the counter increments. In every other case the value holds.

The enable pair is split. `cep` goes to every digit stage in common. `cet` enters the lowest stage, and each stage's terminal-count flag drives the `cet` of the stage above it, so a carry ripples forward without an extra register. Inside the top module the stages are chained this way, so the whole word behaves as one `DIGIT_W*STAGES`-bit binary counter. The `tc` output is high only while `cet` is high and every bit of `q` is one, which lets several such blocks be chained in turn. If `clear_n` is driven from a decode of a chosen count value, the counting cycle becomes shorter, because the clear only acts on the following edge.

Top module: `pcnt_chain`

## Requirements
- R1: `q` changes only at a rising edge of `clk`; a pulse on `clear_n`, `load_n`, `cep`, `cet` or `d` between edges leaves `q` unchanged.
- R2: When `clear_n` is 0 at a rising edge, `q` becomes all zeros, whatever the levels of `load_n`, `cep`, `cet` and `d`.
- R3: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `q` takes the value of `d`, whatever the levels of `cep` and `cet`.
- R4: When `clear_n` and `load_n` are both 1, `q` increments by one at the edge only if `cep` and `cet` are both 1; if either is 0, `q` holds.
- R5: Counting from the all-ones word gives the all-zeros word on the next edge.
- R6: `tc` is combinational and equals 1 exactly when `cet` is 1 and every bit of `q` is 1. After a load of all ones with `cet` at 1, `tc` is high in the cycle that directly follows the load edge.
- R7: The chained word counts as a single binary number: a carry out of each 4-bit digit advances the next digit on the same edge. A load or clear acts on all digits in the same cycle.
- R8: Driving `clear_n` low from a decode of `q` equal to a value V makes the counter run through 0..V and then return to 0, giving a cycle of V+1 states.

Ports of the top module (`TW` = `DIGIT_W*STAGES`, 8 at the default parameters):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cep | input | 1 | Count enable shared by all digits |
| cet | input | 1 | Count enable that also gates `tc` and feeds the carry chain |
| d | input | TW | Parallel load data |
| q | output | TW | Counter value |
| tc | output | 1 | Terminal count: `cet` high and `q` all ones |

## Verification
The bench goes after the priority corners: a clear asserted together with a load and both enables, and a load asserted with the enables low. A design that ranked these wrongly would load or count instead of zeroing, or ignore the load. It also crosses the digit boundary (0x0F to 0x10) and the full-word wrap (0xFF to 0x00). A broken carry chain would leave the upper digit frozen or make it step on every edge, and a wrong wrap would saturate. The bench also probes `tc` right after a load of 0xFF and with `cet` low. A registered or ungated `tc` would show up one cycle late or while the count is inhibited. Glitches between edges and a decoded clear that shortens the cycle catch any path that acts asynchronously.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

   // Action chosen for one clock edge, in priority order
   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_COUNT = 2'd2,
      OP_HOLD  = 2'd3
   } pcnt_op_e;

   localparam int unsigned PCNT_DIGIT_W_DEF = 4;
   localparam int unsigned PCNT_STAGES_DEF  = 2;

endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
   import pcnt_pkg::*;
(
   input  logic     clear_n,
   input  logic     load_n,
   input  logic     cep,
   input  logic     cet,
   output pcnt_op_e op
);

   // Fixed priority: clear, then load, then count, else hold
   always_comb begin
      if (!clear_n)          op = OP_CLEAR;
      else if (!load_n)      op = OP_LOAD;
      else if (cep && cet)   op = OP_COUNT;
      else                   op = OP_HOLD;
   end

endmodule

// File: rtl/pcnt_term.sv
module pcnt_term #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] value,
   input  logic         en,
   output logic         term
);

   // Purely combinational: no register between value and flag
   assign term = en & (&value);

endmodule

// File: rtl/pcnt_stage.sv
module pcnt_stage
   import pcnt_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         clear_n,
   input  logic         load_n,
   input  logic         cep,
   input  logic         cet,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         tc
);

   pcnt_op_e     op;
   logic [W-1:0] cnt_r;
   logic [W-1:0] cnt_nxt;

   pcnt_ctrl i_ctrl (
      .clear_n (clear_n),
      .load_n  (load_n),
      .cep     (cep),
      .cet     (cet),
      .op      (op)
   );

   always_comb begin
      unique case (op)
         OP_CLEAR: cnt_nxt = '0;
         OP_LOAD:  cnt_nxt = d;
         OP_COUNT: cnt_nxt = cnt_r + 1'b1;
         default:  cnt_nxt = cnt_r;
      endcase
   end

   always_ff @(posedge clk) begin
      cnt_r <= cnt_nxt;
   end

   pcnt_term #(.W(W)) i_term (
      .value (cnt_r),
      .en    (cet),
      .term  (tc)
   );

   assign q = cnt_r;

endmodule

// File: rtl/pcnt_chain.sv
module pcnt_chain
   import pcnt_pkg::*;
#(
   parameter int unsigned DIGIT_W = PCNT_DIGIT_W_DEF,
   parameter int unsigned STAGES  = PCNT_STAGES_DEF
) (
   input  logic                        clk,
   input  logic                        clear_n,
   input  logic                        load_n,
   input  logic                        cep,
   input  logic                        cet,
   input  logic [DIGIT_W*STAGES-1:0]   d,
   output logic [DIGIT_W*STAGES-1:0]   q,
   output logic                        tc
);

   localparam int unsigned TOTAL_W = DIGIT_W * STAGES;

   // Elaboration-time parameter checks
   if (DIGIT_W < 1) begin : g_bad_digit
      $error("pcnt_chain: DIGIT_W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("pcnt_chain: STAGES must be at least 1");
   end

   logic [STAGES-1:0] stage_cet;
   logic [STAGES-1:0] stage_tc;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         assign stage_cet[s] = cet;
      end else begin : g_link
         // Lookahead: carry enable comes from the lower digit's flag
         assign stage_cet[s] = stage_tc[s-1];
      end

      pcnt_stage #(.W(DIGIT_W)) i_stage (
         .clk     (clk),
         .clear_n (clear_n),
         .load_n  (load_n),
         .cep     (cep),
         .cet     (stage_cet[s]),
         .d       (d[s*DIGIT_W +: DIGIT_W]),
         .q       (q[s*DIGIT_W +: DIGIT_W]),
         .tc      (stage_tc[s])
      );
   end

   assign tc = stage_tc[STAGES-1];

   if (TOTAL_W == 0) begin : g_never
      $error("pcnt_chain: empty counter");
   end

endmodule

// File: rtl/pcnt_chain_chk.sv
module pcnt_chain_chk #(
   parameter int unsigned DIGIT_W = 4,
   parameter int unsigned STAGES  = 2
) (
   input logic                      clk,
   input logic                      clear_n,
   input logic                      load_n,
   input logic                      cep,
   input logic                      cet,
   input logic [DIGIT_W*STAGES-1:0] d,
   input logic [DIGIT_W*STAGES-1:0] q,
   input logic                      tc
);

   localparam int unsigned TW = DIGIT_W * STAGES;

   // The word is unknown until a first clear or load has landed
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clear_n || !load_n) armed <= 1'b1;
   end

   assert_clear_R2: assert property (@(posedge clk) disable iff (!armed)
      !clear_n |=> (q == '0));

   assert_load_R3: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && !load_n) |=> (q == $past(d)));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && load_n && !(cep && cet)) |=> $stable(q));

   // Increment over the full word, wrapping from all ones (R5, R7)
   assert_count_R4: assert property (@(posedge clk) disable iff (!armed)
      (clear_n && load_n && cep && cet) |=> (q == TW'($past(q) + 1'b1)));

   assert_tc_set_R6: assert property (@(posedge clk) disable iff (!armed)
      (cet && (&q)) |-> tc);

   assert_tc_gate_R6: assert property (@(posedge clk) disable iff (!armed)
      tc |-> (cet && (&q)));

endmodule

bind pcnt_chain pcnt_chain_chk #(.DIGIT_W(DIGIT_W), .STAGES(STAGES)) i_pcnt_chain_chk (
   .clk     (clk),
   .clear_n (clear_n),
   .load_n  (load_n),
   .cep     (cep),
   .cet     (cet),
   .d       (d),
   .q       (q),
   .tc      (tc)
);

// File: tb/test_pcnt_chain.sv
module test_pcnt_chain;

   localparam int CLK_PERIOD = 10;
   localparam int DIGIT_W    = 4;
   localparam int STAGES     = 2;
   localparam int TW         = DIGIT_W * STAGES;

   logic          clk = 1'b0;
   logic          clear_n = 1'b1;
   logic          load_n = 1'b1;
   logic          cep = 1'b0;
   logic          cet = 1'b0;
   logic [TW-1:0] d = '0;
   logic [TW-1:0] q;
   logic          tc;

   pcnt_chain #(.DIGIT_W(DIGIT_W), .STAGES(STAGES)) i_pcnt_chain (
      .clk (clk), .clear_n (clear_n), .load_n (load_n), .cep (cep),
      .cet (cet), .d (d), .q (q), .tc (tc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [TW-1:0] q;
      string         req;
   } item_t;

   item_t         sb[$];
   logic [TW-1:0] mq;
   bit            mq_valid = 0;
   int            checks = 0;
   int            errors = 0;
   bit            done = 0;

   task automatic check(bit ok, string req, string what, logic [TW-1:0] act, logic [TW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Driver: apply one edge's inputs, check tc, push the expected next word
   task automatic drive(bit cl, bit ld, bit ep, bit et, logic [TW-1:0] dv, string req, bit glitch = 0);
      logic [TW-1:0] nxt;
      @(negedge clk);
      clear_n = cl; load_n = ld; cep = ep; cet = et; d = dv;
      #1;
      if (mq_valid)
         check(tc === (et && (&mq)), "R6", "tc", TW'(tc), TW'(et && (&mq)));
      if (glitch && mq_valid) begin
         // R1: pulses between edges must not move q
         clear_n = 0; load_n = 0; d = ~dv; #1;
         clear_n = cl; load_n = ld; d = dv; #1;
         check(q === mq, "R1", "q after mid-cycle pulse", q, mq);
      end
      if (!cl)              begin nxt = '0;  mq_valid = 1; end
      else if (!ld)         begin nxt = dv;  mq_valid = 1; end
      else if (ep && et)    nxt = mq + 1'b1;
      else                  nxt = mq;
      if (mq_valid) sb.push_back('{q: nxt, req: req});
      mq = nxt;
   endtask

   // Monitor: compare q after every edge that has an expected item
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(q === it.q, it.req, "q", q, it.q);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R2: clear wins over load and both enables; reset state is zero
      drive(0, 0, 1, 1, 8'hA5, "R2");
      drive(0, 1, 1, 1, 8'h00, "R2");
      // R4: counting needs both enables
      drive(1, 1, 1, 1, 8'h00, "R4");
      drive(1, 1, 1, 1, 8'h00, "R4");
      drive(1, 1, 0, 1, 8'h00, "R4");
      drive(1, 1, 1, 0, 8'h00, "R4");
      drive(1, 1, 1, 1, 8'h33, "R4", 1);
      // R3: load ignores enables
      drive(1, 0, 0, 0, 8'h3C, "R3");
      drive(1, 0, 1, 1, 8'h0E, "R3");
      // R7: carry crosses the digit boundary
      drive(1, 1, 1, 1, 8'h00, "R7");
      drive(1, 1, 1, 1, 8'h00, "R7");
      drive(1, 1, 1, 1, 8'h00, "R7", 1);
      // R6: load all ones with cet high, tc in the next cycle
      drive(1, 0, 0, 1, 8'hFF, "R6");
      drive(1, 1, 0, 1, 8'h00, "R6");
      drive(1, 1, 1, 0, 8'h00, "R6");
      // R5: wrap from all ones
      drive(1, 1, 1, 1, 8'h00, "R5");
      drive(1, 1, 1, 1, 8'h00, "R5");
      // R7: whole-word load then clear in one cycle each
      drive(1, 0, 1, 1, 8'hEF, "R7");
      drive(1, 1, 1, 1, 8'h00, "R7");
      drive(0, 1, 1, 1, 8'h00, "R7");
      // R8: decoded clear at value 5 gives a 6-state cycle
      for (int i = 0; i < 14; i++) begin
         drive((mq == 8'd5) ? 1'b0 : 1'b1, 1, 1, 1, 8'h00, "R8");
      end
      @(negedge clk);
      cep = 0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule